// File: doc/BRIEF.md
# Aligned FIFO Sample Byte Streamer

This block feeds the read path of a byte-serial slave port from a FIFO whose entries are 16-bit samples. Each sample carries a 2-bit axis tag in bits 15:14 and a 14-bit value in bits 13:0. The serial engine asks for one byte at a time. The streamer answers each request with the next byte of the current head sample, low byte first and then high byte. It pops the FIFO once a sample has been fully handed out.

A transaction can end after an odd number of bytes, leaving a sample half read. In that case the streamer treats the sample as consumed: it pops the sample and drops its high byte. The next transaction therefore always opens on the low byte of a fresh sample. Requests made while the FIFO is empty return zero and leave the FIFO alone. The FIFO storage and the serial shifter are outside this block.

Top module: `fifo_sample_streamer`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), tx_byte is 0x00, fifo_pop is low, and the next accepted request returns the low byte of the head sample.
- R2: Within a sample, the first accepted request returns head bits 7:0 and the second returns head bits 15:8. The second byte carries the axis tag in its bits 7:6.
- R3: fifo_pop is a combinational pulse, asserted in the same cycle as the request that takes the high byte. tx_byte shows the requested byte from the clock edge that ends the request cycle.
- R4: Requests on consecutive cycles stream consecutive samples with no gap or repeated byte.
- R5: When xfer_end arrives while only the low byte of a sample has been sent, fifo_pop is asserted in that cycle. The following request returns the low byte of the next sample.
- R6: When xfer_end arrives on a sample boundary, fifo_pop stays low.
- R7: A request while fifo_empty is high loads 0x00 into tx_byte and does not assert fifo_pop.
- R8: A request in the same cycle as xfer_end is ignored: tx_byte keeps its value and no byte of the sample is consumed by it.
- R9: tx_byte holds its value in every cycle with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_word | input | 16 | Sample at the FIFO head (tag 15:14, value 13:0) |
| fifo_empty | input | 1 | FIFO holds no sample |
| byte_req | input | 1 | Single-cycle request for the next byte |
| xfer_end | input | 1 | Single-cycle strobe at transaction end (chip select released) |
| tx_byte | output | 8 | Byte to be shifted out, registered |
| fifo_pop | output | 1 | Remove the head sample this cycle |

## Verification
The assertions assume that the FIFO never reports empty while a sample is half sent. They also assume that the head word changes only after a pop, because nothing else may take a sample the streamer has started. The bench models the FIFO as a list of known samples whose read pointer moves only on fifo_pop, so both conditions hold throughout. Odd and even transaction ends, simultaneous request and end, and requests on an empty FIFO are all driven through that model.

// File: rtl/fss_pkg.sv
// Shared widths and the sample layout for the FIFO sample streamer.
// Assumes a sample splits into a whole number of bytes.
package fss_pkg;
    localparam int SAMPLE_W = 16;
    localparam int BYTE_W   = 8;
    localparam int TAG_W    = 2;
    localparam int VALUE_W  = SAMPLE_W - TAG_W;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [VALUE_W-1:0] value;
    } sample_t;
endpackage

// File: rtl/fss_phase_ctrl.sv
// Byte-phase tracker: counts which byte of the head sample is next and
// decides when the head sample is popped. Assumes the FIFO is not empty
// while a sample is partly sent and that xfer_end is a one-cycle strobe.
module fss_phase_ctrl #(
    parameter int NBYTES = 2,
    localparam int PH_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_req,
    input  logic            xfer_end,
    input  logic            fifo_empty,
    output logic [PH_W-1:0] phase,
    output logic            take,
    output logic            pop
);
    localparam logic [PH_W-1:0] LAST = PH_W'(NBYTES - 1);

    logic last_byte;
    logic mid_sample;

    // Decode request acceptance and the pop condition.
    always_comb begin
        take       = byte_req && !xfer_end && !fifo_empty;
        last_byte  = (phase == LAST);
        mid_sample = (phase != '0);
        pop        = (take && last_byte) || (xfer_end && mid_sample);
    end

    // Advance the phase on each accepted byte, realign at transaction end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (xfer_end) begin
            phase <= '0;
        end else if (take) begin
            phase <= last_byte ? '0 : phase + 1'b1;
        end
    end

    // R5: a transaction end always leaves the next read aligned.
    p_end_realign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> (phase == '0));

    // R6: ending on a sample boundary never pops.
    p_even_end_no_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && phase == '0) |-> !pop);

    // R7: an empty FIFO is never popped.
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);

    // Input assumption: a half-sent sample stays in the FIFO.
    p_mid_sample_present: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> !fifo_empty);

    // R8: a request in the end cycle does not move the phase forward.
    p_req_at_end_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && xfer_end) |=> (phase == '0));
endmodule

// File: rtl/fss_byte_mux.sv
// Byte selector and output register: slices the head sample into bytes,
// picks the one named by the phase and holds it until the next accepted
// request. An empty FIFO yields zero. Assumes phase < NBYTES.
module fss_byte_mux #(
    parameter int SAMPLE_W = 16,
    parameter int BYTE_W   = 8,
    localparam int NBYTES  = SAMPLE_W / BYTE_W,
    localparam int PH_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] head_word,
    input  logic [PH_W-1:0]     phase,
    input  logic                byte_req,
    input  logic                xfer_end,
    input  logic                fifo_empty,
    output logic [BYTE_W-1:0]   tx_byte
);
    logic [BYTE_W-1:0] lane [NBYTES];
    logic [BYTE_W-1:0] pick;
    logic              load;

    // One lane per byte of the sample, least significant lane first.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = head_word[g*BYTE_W +: BYTE_W];
    end

    // Select the byte for the current phase, zero when nothing is queued.
    always_comb begin
        load = byte_req && !xfer_end;
        pick = fifo_empty ? '0 : lane[phase];
    end

    // Register the outgoing byte on each request outside an end cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
        end else if (load) begin
            tx_byte <= pick;
        end
    end

    // R7: a request on an empty FIFO returns zero.
    p_empty_gives_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !xfer_end && fifo_empty) |=> (tx_byte == '0));

    // R9: the output holds without an accepted request.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_req && !xfer_end) |=> $stable(tx_byte));
endmodule

// File: rtl/fifo_sample_streamer.sv
// Top of the FIFO sample streamer. Turns 16-bit tagged samples into a
// low-then-high byte stream for a serial read path and keeps every
// transaction aligned to a sample boundary. Assumes the FIFO head only
// changes after fifo_pop and that strobes are one cycle wide.
module fifo_sample_streamer
    import fss_pkg::*;
#(
    parameter int SAMPLE_BITS = SAMPLE_W,
    parameter int BYTE_BITS   = BYTE_W,
    localparam int NBYTES     = SAMPLE_BITS / BYTE_BITS,
    localparam int PH_W       = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SAMPLE_BITS-1:0] head_word,
    input  logic                   fifo_empty,
    input  logic                   byte_req,
    input  logic                   xfer_end,
    output logic [BYTE_BITS-1:0]   tx_byte,
    output logic                   fifo_pop
);
    logic [PH_W-1:0] phase;
    logic            take;

    fss_phase_ctrl #(
        .NBYTES (NBYTES)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_req   (byte_req),
        .xfer_end   (xfer_end),
        .fifo_empty (fifo_empty),
        .phase      (phase),
        .take       (take),
        .pop        (fifo_pop)
    );

    fss_byte_mux #(
        .SAMPLE_W (SAMPLE_BITS),
        .BYTE_W   (BYTE_BITS)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_word  (head_word),
        .phase      (phase),
        .byte_req   (byte_req),
        .xfer_end   (xfer_end),
        .fifo_empty (fifo_empty),
        .tx_byte    (tx_byte)
    );

    // R2/R3: a pop caused by a request emits the top byte of that sample.
    p_pop_sends_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fifo_pop) |=> (tx_byte == $past(head_word[SAMPLE_BITS-1 -: BYTE_BITS])));

    // R2: the first byte taken from a sample is its low byte.
    p_low_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fifo_pop) |=> (tx_byte == $past(head_word[BYTE_BITS-1:0])));

    // R1: reset leaves the output at zero.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (tx_byte == '0));
endmodule

// File: tb/fifo_sample_streamer_tb.sv
// Bench: a modelled FIFO of four known samples, a vector table walked by
// one loop, then directed reset and back-to-back checks.
module fifo_sample_streamer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] head_word;
    logic        fifo_empty;
    logic        byte_req = 1'b0;
    logic        xfer_end = 1'b0;
    logic [7:0]  tx_byte;
    logic        fifo_pop;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    // Modelled FIFO contents and read pointer.
    localparam logic [15:0] MEM [4] = '{16'h8123, 16'h4AB5, 16'hC3FE, 16'h1234};
    int rd = 0;
    assign fifo_empty = (rd >= 4);
    assign head_word  = fifo_empty ? 16'h0000 : MEM[rd];

    always_ff @(posedge clk) begin
        if (fifo_pop) rd <= rd + 1;
    end

    fifo_sample_streamer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_word  (head_word),
        .fifo_empty (fifo_empty),
        .byte_req   (byte_req),
        .xfer_end   (xfer_end),
        .tx_byte    (tx_byte),
        .fifo_pop   (fifo_pop)
    );

    // Vector: {req, end, expected pop, expected tx after edge, requirement}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'h23, 4'd2},  // low byte of S0
        {1'b1, 1'b0, 1'b1, 8'h81, 4'd3},  // high byte, pop
        {1'b1, 1'b0, 1'b0, 8'hB5, 4'd4},  // low byte of S1 back to back
        {1'b0, 1'b1, 1'b1, 8'hB5, 4'd5},  // odd end drops S1 high byte
        {1'b1, 1'b0, 1'b0, 8'hFE, 4'd5},  // next read starts on S2 low
        {1'b1, 1'b0, 1'b1, 8'hC3, 4'd4},  // S2 high
        {1'b0, 1'b1, 1'b0, 8'hC3, 4'd6},  // even end, no pop
        {1'b0, 1'b0, 1'b0, 8'hC3, 4'd9},  // idle hold
        {1'b1, 1'b1, 1'b0, 8'hC3, 4'd8},  // request at end ignored
        {1'b1, 1'b0, 1'b0, 8'h34, 4'd8},  // S3 low still first
        {1'b1, 1'b1, 1'b1, 8'h34, 4'd8},  // end wins, drops S3 high
        {1'b1, 1'b0, 1'b0, 8'h00, 4'd7},  // empty returns zero
        {1'b1, 1'b0, 1'b0, 8'h00, 4'd7},  // empty again
        {1'b0, 1'b1, 1'b0, 8'h00, 4'd6}   // end on empty, no pop
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic step(input logic rq, input logic en);
        byte_req = rq;
        xfer_end = en;
    endtask

    initial begin
        #(20 * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check("R1 tx at reset", tx_byte, 8'h00);
        check("R1 pop at reset", {7'd0, fifo_pop}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[3:0], i);
            step(v[14], v[13]);
            #2;
            check({tag, " pop"}, {7'd0, fifo_pop}, {7'd0, v[12]});
            @(negedge clk);
            check({tag, " tx"}, tx_byte, v[11:4]);
        end
        step(1'b0, 1'b0);

        // R1: reset mid-sample, then restart aligned with the pointer at 0
        rd = 0;
        @(negedge clk);
        step(1'b1, 1'b0);
        @(negedge clk);
        step(1'b0, 1'b0);
        check("R2 low byte before reset", tx_byte, 8'h23);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 tx cleared by reset", tx_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: four back-to-back requests after reset
        begin
            logic [7:0] exp4 [4];
            exp4 = '{8'h23, 8'h81, 8'hB5, 8'h4A};
            for (int k = 0; k < 4; k++) begin
                step(1'b1, 1'b0);
                #2;
                check("R3 pop on high byte", {7'd0, fifo_pop}, {7'd0, (k % 2 == 1)});
                @(negedge clk);
                check("R4 streamed byte", tx_byte, exp4[k]);
            end
        end
        step(1'b0, 1'b0);
        @(negedge clk);
        check("R9 hold after burst", tx_byte, 8'h4A);
        finish_run();
    end
endmodule